// File: doc/BRIEF.md
# Codec Register Access Controller for a Serial Audio Link

This block connects a host register port to the frame engine of a serial audio codec link. It turns each host read or write of a codec register into a command carried in the next outgoing frame. For every frame it builds the 16-bit tag word that marks which slots are valid and which codec is addressed, and it fills the command address and command data slots. Only one codec access may be on the link at a time. A semaphore bit, `busy`, tells the host when it may issue the next access.

Writes are posted. The host port treats a write as done as soon as it is accepted, and `busy` keeps further accesses out until the frame carrying the write has been handed to the frame engine. A link read keeps `busy` set until the codec echoes the register index with data. If no answer arrives within a programmable number of frames, the read is abandoned and an error flag is set. The block keeps a local copy of each codec's incoming status slot (slot 12). Reads of the status register come from that copy at once. Writes to the status register go out on the link and also update the copy.

The frame engine pulses `frame_load` once per frame and then shifts out the three registered output words. It pulses `in_valid` once it has received a complete incoming frame.

Top module: `acl_reg_access`

## Requirements
- R1: Every frame boundary (`frame_load` high at a clock edge) loads `out_tag` with bit 15 set to 1 and bit 2 set to 0.
- R2: At each frame boundary, `out_tag[12:3]` takes the value of `data_slot_valid` sampled on that edge.
- R3: Host address bits 8:7 select the codec: 0 is primary, 1 is secondary, 2 is tertiary, and 3 makes the request ignored. Bits 6:0 are the register index. A command frame has `out_slot1 = {read, index, 12'b0}`, where read is 1 for a read and 0 for a write. A write has `out_slot2 = {wdata, 4'b0}`. Slot 2 is zero for a read, and both slots are zero in a frame with no command.
- R4: A primary command sets tag bit 14, sets tag bit 13 only for a write, and places 00 in tag bits 1:0. A secondary or tertiary command leaves bits 14:13 at 0 and places 01 or 10 in bits 1:0. A frame with no command has bits 14:13 and 1:0 at 0.
- R5: An accepted link access raises `busy` on the next cycle. While `busy` is high, every host request except a status read (index 0x54, read) is ignored.
- R6: A write is carried in exactly one frame. `busy` falls on the clock edge of the frame boundary that loads the write, and the following frame carries no command.
- R7: A read keeps `busy` high after it is sent, until `in_valid` arrives with `in_tag[13]=1` and `in_slot1[18:12]` equal to the read's index. On the next cycle `host_rvalid` pulses with `host_rdata = in_slot2[19:4]`, and `busy` is low. Incoming frames that do not match have no effect.
- R8: Frame boundaries are counted after the one that sent a read. When this count reaches the larger of `tmo_limit` and 1 with no response, `busy` falls and `timeout_err` rises. A matching response on that same edge takes priority. `timeout_err` clears when the next link access is accepted.
- R9: A read of index 0x54 for codec 0, 1 or 2 does not use the link and does not touch `busy`, even while `busy` is high. One cycle later `host_rvalid` pulses with that codec's status copy as it stood before the request's edge. If a link response completes on the same edge, the response wins and the status read is dropped.
- R10: `in_valid` with `in_tag[3]=1` updates the status copy of codec `in_tag[1:0]` to `in_slot12[19:4]`. An ID of 3 updates nothing.
- R11: An accepted write to index 0x54 also updates that codec's status copy on the accepting edge. When a link update to the same codec falls on the same edge, the host write takes priority.
- R12: After reset, `busy`, `host_rvalid`, `timeout_err`, `out_tag`, both output slots and all status copies are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, one cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 9 | Codec select (8:7) and register index (6:0) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data pulse |
| busy | output | 1 | Semaphore: a codec access is in flight |
| timeout_err | output | 1 | Last read was abandoned by timeout |
| tmo_limit | input | 8 | Read timeout in frames |
| frame_load | input | 1 | Frame boundary from the frame engine |
| data_slot_valid | input | 10 | Valid flags of slots 3..12 for the tag |
| out_tag | output | 16 | Outgoing slot-0 tag |
| out_slot1 | output | 20 | Outgoing command address slot |
| out_slot2 | output | 20 | Outgoing command data slot |
| in_valid | input | 1 | Incoming frame received |
| in_tag | input | 16 | Incoming tag |
| in_slot1 | input | 20 | Incoming echoed register index |
| in_slot2 | input | 20 | Incoming register data |
| in_slot12 | input | 20 | Incoming status slot |

## Verification
The hardest situations to reach are the collisions around a pending read. A matching response can land on the same edge as the frame boundary that would time the read out. It can also coincide with a status-copy read, which it must override. The bench keeps the frame boundaries periodic and injects incoming frames at random. Half of these frames echo the index of the read the reference model holds as pending, so responses, timeouts and status reads overlap on many edges. Directed sequences first cover each path on its own, with a small `tmo_limit` so that timeouts occur within a few frames.

// File: rtl/acl_reg_pkg.sv
// Package: shared widths, tag bit positions, command and frame types for
// the codec register access controller.
package acl_reg_pkg;
    localparam int DATA_W  = 16;
    localparam int SLOT_W  = 20;
    localparam int IDX_W   = 7;
    localparam int TAG_W   = 16;
    localparam int DV_W    = 10;
    localparam int CID_W   = 2;
    localparam int HADDR_W = CID_W + IDX_W;
    localparam int NCODEC  = 3;
    localparam int PAD1_W  = SLOT_W - IDX_W - 1;
    localparam int PAD2_W  = SLOT_W - DATA_W;

    localparam int TAG_FRAME = 15;
    localparam int TAG_CADDR = 14;
    localparam int TAG_CDATA = 13;
    localparam int TAG_DV_LO = 3;
    localparam int TAG_S12   = 3;

    localparam logic [IDX_W-1:0] STATUS_IDX = 7'h54;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_PEND, SEQ_WAIT} seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [CID_W-1:0]  cid;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } acl_cmd_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SLOT_W-1:0] s1;
        logic [SLOT_W-1:0] s2;
    } acl_frame_t;
endpackage

// File: rtl/acl_host_decode.sv
// Module: acl_host_decode
// Splits a host request into codec select and register index and classifies
// it as a local status read, a link access, or an ignored request.
// Assumes: codec select value NCODEC and above is not populated.
module acl_host_decode
    import acl_reg_pkg::*;
(
    input  logic               req,
    input  logic               wr,
    input  logic [HADDR_W-1:0] addr,
    output logic [CID_W-1:0]   cid,
    output logic [IDX_W-1:0]   idx,
    output logic               shadow_rd,
    output logic               link_acc
);
    logic addr_ok;

    // Classify the request from its address and direction.
    always_comb begin
        cid       = addr[HADDR_W-1:IDX_W];
        idx       = addr[IDX_W-1:0];
        addr_ok   = int'(cid) < NCODEC;
        shadow_rd = req && addr_ok && !wr && (idx == STATUS_IDX);
        link_acc  = req && addr_ok && !shadow_rd;
    end
endmodule

// File: rtl/acl_tag_builder.sv
// Module: acl_tag_builder
// Forms the outgoing tag and the two command slots for one frame, either
// from the pending command or as a frame without a command.
// Assumes: codec ID 0 is the primary codec, which uses tag bits 14:13.
module acl_tag_builder
    import acl_reg_pkg::*;
(
    input  logic            cmd_valid,
    input  acl_cmd_t        cmd,
    input  logic [DV_W-1:0] dv,
    output acl_frame_t      frame
);
    // Assemble tag and command slots.
    always_comb begin
        frame = '0;
        frame.tag[TAG_FRAME] = 1'b1;
        frame.tag[TAG_DV_LO +: DV_W] = dv;
        if (cmd_valid) begin
            if (cmd.cid == '0) begin
                frame.tag[TAG_CADDR] = 1'b1;
                frame.tag[TAG_CDATA] = cmd.wr;
            end else begin
                frame.tag[CID_W-1:0] = cmd.cid;
            end
            frame.s1 = {~cmd.wr, cmd.idx, {PAD1_W{1'b0}}};
            if (cmd.wr) begin
                frame.s2 = {cmd.data, {PAD2_W{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/acl_slot12_shadow.sv
// Module: acl_slot12_shadow
// Holds one copy of the incoming status slot per codec. A host write beats
// a link update to the same codec on the same edge.
// Assumes: codec IDs at or above NCODEC address no entry.
module acl_slot12_shadow
    import acl_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [CID_W-1:0]  host_cid,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              link_we,
    input  logic [CID_W-1:0]  link_cid,
    input  logic [DATA_W-1:0] link_data,
    input  logic [CID_W-1:0]  rd_cid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] copy_q [NCODEC];

    for (genvar g = 0; g < NCODEC; g++) begin : g_entry
        // Update one codec's copy, host first.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                copy_q[g] <= '0;
            end else if (host_we && host_cid == CID_W'(g)) begin
                copy_q[g] <= host_wdata;
            end else if (link_we && link_cid == CID_W'(g)) begin
                copy_q[g] <= link_data;
            end
        end
    end

    // Select the copy addressed by the read port.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCODEC; i++) begin
            if (rd_cid == CID_W'(i)) rd_data = copy_q[i];
        end
    end
endmodule

// File: rtl/acl_cmd_seq.sv
// Module: acl_cmd_seq
// Holds the single in-flight command: waits for a frame to carry it, then
// for a read waits for the matching echo or a frame-count timeout.
// Assumes: the caller only asserts acc while busy is low.
module acl_cmd_seq
    import acl_reg_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  acl_cmd_t          acc_cmd,
    input  logic              frame_load,
    input  logic              in_valid,
    input  logic              in_cdata_ok,
    input  logic [IDX_W-1:0]  in_echo_idx,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              busy,
    output logic              send_valid,
    output acl_cmd_t          cmd,
    output logic              rsp_hit,
    output logic              tmo_err
);
    seq_state_e       state_q;
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] cnt_next;
    logic [TMO_W-1:0] limit_eff;
    logic             tmo_hit;

    // Derive status, response match and timeout decision.
    always_comb begin
        busy       = state_q != SEQ_IDLE;
        send_valid = state_q == SEQ_PEND;
        rsp_hit    = (state_q == SEQ_WAIT) && in_valid && in_cdata_ok
                     && (in_echo_idx == cmd.idx);
        cnt_next   = cnt_q + 1'b1;
        limit_eff  = (tmo_limit == '0) ? TMO_W'(1) : tmo_limit;
        tmo_hit    = (state_q == SEQ_WAIT) && frame_load && !rsp_hit
                     && (cnt_next >= limit_eff);
    end

    // Advance the access state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (acc) state_q <= SEQ_PEND;
                SEQ_PEND: if (frame_load) state_q <= cmd.wr ? SEQ_IDLE : SEQ_WAIT;
                SEQ_WAIT: if (rsp_hit || tmo_hit) state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Capture the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
        end else if (state_q == SEQ_IDLE && acc) begin
            cmd <= acc_cmd;
        end
    end

    // Count frames while a read waits for its echo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == SEQ_PEND) begin
            cnt_q <= '0;
        end else if (state_q == SEQ_WAIT && frame_load && !rsp_hit) begin
            cnt_q <= cnt_next;
        end
    end

    // Raise the error on timeout, drop it on the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_err <= 1'b0;
        end else if (state_q == SEQ_IDLE && acc) begin
            tmo_err <= 1'b0;
        end else if (tmo_hit) begin
            tmo_err <= 1'b1;
        end
    end
endmodule

// File: rtl/acl_reg_access.sv
// Module: acl_reg_access (top)
// Codec register access controller: host port to per-frame command slots,
// one access in flight with a polled semaphore, posted writes, and local
// status-slot copies for immediate status reads.
// Assumes: frame_load and in_valid are single-cycle pulses from the frame
// engine; the output words are taken by the engine after frame_load.
module acl_reg_access
    import acl_reg_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_wr,
    input  logic [HADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_rvalid,
    output logic                 busy,
    output logic                 timeout_err,
    input  logic [TMO_W-1:0]     tmo_limit,
    input  logic                 frame_load,
    input  logic [DV_W-1:0]      data_slot_valid,
    output logic [TAG_W-1:0]     out_tag,
    output logic [SLOT_W-1:0]    out_slot1,
    output logic [SLOT_W-1:0]    out_slot2,
    input  logic                 in_valid,
    input  logic [TAG_W-1:0]     in_tag,
    input  logic [SLOT_W-1:0]    in_slot1,
    input  logic [SLOT_W-1:0]    in_slot2,
    input  logic [SLOT_W-1:0]    in_slot12
);
    logic [CID_W-1:0]  req_cid;
    logic [IDX_W-1:0]  req_idx;
    logic              shadow_rd;
    logic              link_acc;
    logic              accept;
    logic              send_valid;
    acl_cmd_t          cur_cmd;
    acl_cmd_t          new_cmd;
    logic              rsp_hit;
    acl_frame_t        next_frame;
    logic [DATA_W-1:0] shadow_data;
    logic              shadow_we;
    logic              link_we;
    logic              unused_bits;

    assign unused_bits = ^{in_tag[TAG_W-1:TAG_CDATA+1], in_tag[TAG_CDATA-1:TAG_S12+1],
                           in_tag[TAG_S12-1:CID_W], in_slot1[SLOT_W-1],
                           in_slot1[PAD1_W-1:0], in_slot2[PAD2_W-1:0],
                           in_slot12[PAD2_W-1:0]};

    acl_host_decode u_dec (
        .req       (host_req),
        .wr        (host_wr),
        .addr      (host_addr),
        .cid       (req_cid),
        .idx       (req_idx),
        .shadow_rd (shadow_rd),
        .link_acc  (link_acc)
    );

    // Form the command offered to the sequencer and the shadow write strobes.
    always_comb begin
        accept    = link_acc && !busy;
        new_cmd   = '{wr: host_wr, cid: req_cid, idx: req_idx, data: host_wdata};
        shadow_we = accept && host_wr && (req_idx == STATUS_IDX);
        link_we   = in_valid && in_tag[TAG_S12];
    end

    acl_cmd_seq #(.TMO_W(TMO_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (accept),
        .acc_cmd     (new_cmd),
        .frame_load  (frame_load),
        .in_valid    (in_valid),
        .in_cdata_ok (in_tag[TAG_CDATA]),
        .in_echo_idx (in_slot1[SLOT_W-2 -: IDX_W]),
        .tmo_limit   (tmo_limit),
        .busy        (busy),
        .send_valid  (send_valid),
        .cmd         (cur_cmd),
        .rsp_hit     (rsp_hit),
        .tmo_err     (timeout_err)
    );

    acl_tag_builder u_tag (
        .cmd_valid (send_valid),
        .cmd       (cur_cmd),
        .dv        (data_slot_valid),
        .frame     (next_frame)
    );

    acl_slot12_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (shadow_we),
        .host_cid   (req_cid),
        .host_wdata (host_wdata),
        .link_we    (link_we),
        .link_cid   (in_tag[CID_W-1:0]),
        .link_data  (in_slot12[SLOT_W-1 -: DATA_W]),
        .rd_cid     (req_cid),
        .rd_data    (shadow_data)
    );

    // Load the outgoing frame words at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tag   <= '0;
            out_slot1 <= '0;
            out_slot2 <= '0;
        end else if (frame_load) begin
            out_tag   <= next_frame.tag;
            out_slot1 <= next_frame.s1;
            out_slot2 <= next_frame.s2;
        end
    end

    // Return read data: link response first, else the status copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rsp_hit || shadow_rd;
            if (rsp_hit) begin
                host_rdata <= in_slot2[SLOT_W-1 -: DATA_W];
            end else if (shadow_rd) begin
                host_rdata <= shadow_data;
            end
        end
    end
endmodule

// File: rtl/acl_reg_access_chk.sv
// Module: acl_reg_access_chk
// Protocol checks on the ports of acl_reg_access, attached by bind.
module acl_reg_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_rvalid,
    input logic        busy,
    input logic        frame_load,
    input logic        in_valid,
    input logic [9:0]  data_slot_valid,
    input logic [15:0] out_tag
);
    assert_frame_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (out_tag[15] && !out_tag[2]));

    assert_slot_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (out_tag[12:3] == $past(data_slot_valid)));

    assert_codec_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_tag[1:0] != 2'b11);

    assert_cmd_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tag[1:0] != 2'b00) |-> (out_tag[14:13] == 2'b00));

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_load && !in_valid) |=> busy);

    assert_busy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(frame_load) || $past(in_valid)));

    assert_rvalid_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> ($past(in_valid) || $past(host_req)));
endmodule

bind acl_reg_access acl_reg_access_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_req        (host_req),
    .host_rvalid     (host_rvalid),
    .busy            (busy),
    .frame_load      (frame_load),
    .in_valid        (in_valid),
    .data_slot_valid (data_slot_valid),
    .out_tag         (out_tag)
);

// File: tb/acl_reg_access_test.sv
// Bench for acl_reg_access: directed sequences with literal expectations,
// then random traffic against a behavioural reference model compared on
// every clock.
module acl_reg_access_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        busy;
    logic        timeout_err;
    logic [7:0]  tmo_limit = 8'd4;
    logic        frame_load = 1'b0;
    logic [9:0]  data_slot_valid = '0;
    logic [15:0] out_tag;
    logic [19:0] out_slot1;
    logic [19:0] out_slot2;
    logic        in_valid = 1'b0;
    logic [15:0] in_tag = '0;
    logic [19:0] in_slot1 = '0;
    logic [19:0] in_slot2 = '0;
    logic [19:0] in_slot12 = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_en = 0;

    acl_reg_access uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit [25:0]   pend_q[$];
    bit          m_wait, m_busy, m_rv, m_err;
    int          m_cnt, m_lim;
    bit [6:0]    m_widx;
    bit [15:0]   m_rd, m_tag;
    bit [19:0]   m_s1, m_s2;
    bit [15:0]   sh[3];
    int          r_cid;
    bit [6:0]    r_idx;
    bit          r_shrd, r_lk, r_busy_old;
    bit [25:0]   e;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend_q.delete();
            m_wait = 0; m_busy = 0; m_rv = 0; m_err = 0; m_cnt = 0; m_rd = 0;
            m_tag = 0; m_s1 = 0; m_s2 = 0;
            foreach (sh[i]) sh[i] = 0;
        end else begin
            r_busy_old = m_busy;
            r_cid  = int'(host_addr[8:7]);
            r_idx  = host_addr[6:0];
            r_shrd = host_req && r_cid < 3 && !host_wr && r_idx == 7'h54;
            r_lk   = host_req && r_cid < 3 && !r_shrd;
            m_rv = 0;
            if (m_wait && in_valid && in_tag[13] && in_slot1[18:12] == m_widx) begin
                m_rv = 1; m_rd = in_slot2[19:4]; m_wait = 0;
            end else begin
                if (r_shrd) begin m_rv = 1; m_rd = sh[r_cid]; end
                if (m_wait && frame_load) begin
                    m_cnt++;
                    m_lim = (tmo_limit == 0) ? 1 : int'(tmo_limit);
                    if (m_cnt >= m_lim) begin m_wait = 0; m_err = 1; end
                end
            end
            if (frame_load) begin
                m_tag = 16'h8000 | {3'b000, data_slot_valid, 3'b000};
                m_s1 = 0; m_s2 = 0;
                if (pend_q.size() > 0) begin
                    e = pend_q.pop_front();
                    if (e[24:23] == 2'd0) m_tag = m_tag | 16'h4000 | (e[25] ? 16'h2000 : 16'h0);
                    else m_tag = m_tag | {14'd0, e[24:23]};
                    m_s1 = {~e[25], e[22:16], 12'd0};
                    if (e[25]) m_s2 = {e[15:0], 4'd0};
                    else begin m_wait = 1; m_cnt = 0; m_widx = e[22:16]; end
                end
            end
            if (in_valid && in_tag[3] && in_tag[1:0] != 2'd3) sh[in_tag[1:0]] = in_slot12[19:4];
            if (r_lk && !r_busy_old) begin
                pend_q.push_back({host_wr, host_addr[8:7], r_idx, host_wdata});
                m_err = 0;
                if (host_wr && r_idx == 7'h54) sh[r_cid] = host_wdata;
            end
            m_busy = pend_q.size() > 0 || m_wait;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(busy == m_busy, "R5 busy", busy, m_busy);
            check(host_rvalid == m_rv, "R7 rvalid", host_rvalid, m_rv);
            if (m_rv) check(host_rdata == m_rd, "R9 rdata", host_rdata, m_rd);
            check(out_tag == m_tag, "R4 tag", out_tag, m_tag);
            check(out_slot1 == m_s1, "R3 slot1", out_slot1, m_s1);
            check(out_slot2 == m_s2, "R3 slot2", out_slot2, m_s2);
            check(timeout_err == m_err, "R8 err", timeout_err, m_err);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic host(input bit wr, input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_load = 1;
        @(negedge clk);
        frame_load = 0;
    endtask

    task automatic rx(input logic [15:0] t, input logic [19:0] s1, input logic [19:0] s2,
                      input logic [19:0] s12);
        @(negedge clk);
        in_valid = 1; in_tag = t; in_slot1 = s1; in_slot2 = s2; in_slot12 = s12;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        check(busy == 0 && host_rvalid == 0 && timeout_err == 0, "R12 status", busy, 0);
        check(out_tag == 0 && out_slot1 == 0 && out_slot2 == 0, "R12 frame", out_tag, 0);
        cmp_en = 1;

        // R1, R2: idle frame carries frame bit and the slot-valid mask
        data_slot_valid = 10'h2A5;
        frame();
        check(out_tag == 16'h9528, "R1 R2 idle tag", out_tag, 16'h9528);
        data_slot_valid = 0;

        // R3, R4, R6: primary write to index 0x02
        host(1, 9'h002, 16'h1234);
        check(busy == 1, "R5 busy after write", busy, 1);
        host(1, 9'h003, 16'h9999);            // ignored while busy (R5)
        frame();
        check(out_tag == 16'hE000, "R4 primary write tag", out_tag, 16'hE000);
        check(out_slot1 == 20'h02000, "R3 write slot1", out_slot1, 20'h02000);
        check(out_slot2 == 20'h12340, "R3 write slot2", out_slot2, 20'h12340);
        check(busy == 0, "R6 busy released", busy, 0);
        frame();
        check(out_tag == 16'h8000 && out_slot1 == 0, "R6 sent once", out_tag, 16'h8000);

        // R3, R4, R7: secondary read index 0x26
        host(0, 9'h0A6, 0);
        frame();
        check(out_tag == 16'h8001, "R4 secondary tag", out_tag, 16'h8001);
        check(out_slot1 == 20'hA6000, "R3 read slot1", out_slot1, 20'hA6000);
        rx(16'h2000, 20'h27000, 20'hDEAD0, 0);   // wrong index
        check(busy == 1 && host_rvalid == 0, "R7 mismatch ignored", busy, 1);
        rx(16'h2000, 20'h26000, 20'hBEEF0, 0);
        check(host_rvalid == 1 && host_rdata == 16'hBEEF, "R7 read data", host_rdata, 16'hBEEF);
        check(busy == 0, "R7 busy cleared", busy, 0);

        // R8: tertiary read times out after 3 frames
        tmo_limit = 8'd3;
        host(0, 9'h12C, 0);
        frame();
        check(out_tag == 16'h8002, "R4 tertiary tag", out_tag, 16'h8002);
        frame(); frame();
        check(busy == 1 && timeout_err == 0, "R8 still waiting", busy, 1);
        frame();
        check(busy == 0 && timeout_err == 1, "R8 timeout", timeout_err, 1);

        // R10, R9: link update of codec 1 status copy, then local read
        rx(16'h0009, 0, 0, 20'h55AA0);
        host(0, 9'h0D4, 0);
        check(host_rvalid == 1 && host_rdata == 16'h55AA, "R10 R9 status read", host_rdata, 16'h55AA);
        check(busy == 0, "R9 no busy", busy, 0);

        // R11, R9: status write on tertiary, read back while busy
        host(1, 9'h154, 16'h7777);
        check(timeout_err == 0, "R8 err cleared", timeout_err, 0);
        host(0, 9'h154, 0);
        check(host_rvalid == 1 && host_rdata == 16'h7777, "R11 shadow write", host_rdata, 16'h7777);
        check(busy == 1, "R9 busy kept", busy, 1);
        frame();
        check(out_slot1 == 20'h54000 && out_tag == 16'h8002, "R11 write on link", out_slot1, 20'h54000);

        // R3: codec select 3 ignored
        host(1, 9'h1C5, 16'h0001);
        check(busy == 0, "R3 select 3 ignored", busy, 0);

        // Random traffic against the reference model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            frame_load = (cyc % 8) == 0;
            data_slot_valid = 10'($urandom);
            host_req = ($urandom % 5) == 0;
            host_wr = $urandom % 2;
            host_addr = {(($urandom % 8) == 0) ? 2'd3 : 2'($urandom % 3),
                         (($urandom % 3) == 0) ? 7'h54 : 7'($urandom % 8)};
            host_wdata = 16'($urandom);
            in_valid = ($urandom % 4) == 0;
            in_tag = 16'($urandom);
            in_slot1 = {1'b0, (($urandom % 2) == 0) ? m_widx : 7'($urandom % 8), 12'd0};
            in_slot2 = 20'($urandom);
            in_slot12 = 20'($urandom);
            if ((cyc % 200) == 0) tmo_limit = 8'($urandom % 5);
        end
        @(negedge clk);
        host_req = 0; in_valid = 0; frame_load = 0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule